// File: doc/BRIEF.md
# Four-Stage In-Order Pipeline Control with Stall Bubbles

This block is the control skeleton of an in-order pipeline. It has four stages: fetch, decode, execute and write-back. Each stage register holds a valid bit, an instruction tag, the source register indices, a destination register index and a flag that says whether the instruction writes a register. It does no arithmetic. It only decides, on every clock, whether the pipeline advances, stalls or is flushed.

An instruction in decode may read a register that the instruction in execute has not yet written. In that case decode and fetch hold their contents for one cycle, and an empty slot (a bubble) enters execute. The bubble then moves on into write-back and leaves, so every later instruction is one cycle late. A taken-branch strobe means that the instruction now in execute redirects the program. On that edge the two younger instructions and the slot entering execute are discarded, and the upstream source then offers the instruction at the branch target. A registered retire strobe with its tag reports each real instruction as it leaves write-back.

Top module: `pipe4_ctrl`

## Requirements
- R1: When neither a hazard nor a taken branch is present, each slot moves one stage per clock (fetch to decode to execute to write-back). The fetch register captures the input instruction when in_valid is high, and is empty otherwise.
- R2: A hazard exists when decode is valid, execute is valid, execute's write flag is 1, and one of decode's source indices equals execute's destination index.
- R3: During a hazard cycle in_ready is low, and decode and fetch keep their valid bits and tags through the next edge.
- R4: A stall puts an invalid slot into execute on the next edge. That slot is invalid in write-back one edge later and never produces a retire pulse.
- R5: When four instructions run with exactly one single-cycle stall, the fourth reaches write-back 8 edges after the first is captured, counting the capture edge as 1. Without the stall it takes 7.
- R6: When br_taken is high, in_ready is low. On the next edge fetch, decode and execute become invalid, and the instruction that was in execute moves into write-back.
- R7: retire is high on the cycle after write-back held a valid slot, and retire_tag carries that slot's tag. retire is low after every bubble.
- R8: When a taken branch and a hazard occur in the same cycle, the flush takes effect and the stall does not.
- R9: While rst_n is low, every stage valid and retire are 0.
- R10: A matching destination gives no stall when the execute slot's write flag is 0, or when the producer has already moved on to write-back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An instruction is offered to fetch |
| in_tag | input | 8 | Tag of the offered instruction |
| in_src | input | 8 | Two source register indices, index 0 in bits 3:0, index 1 in bits 7:4 |
| in_dst | input | 4 | Destination register index |
| in_wr | input | 1 | Offered instruction writes its destination |
| br_taken | input | 1 | The instruction now in execute is a taken branch |
| in_ready | output | 1 | Fetch accepts the offered instruction on this edge |
| fetch_valid | output | 1 | Fetch stage holds an instruction |
| fetch_tag | output | 8 | Fetch stage tag |
| dec_valid | output | 1 | Decode stage holds an instruction |
| dec_tag | output | 8 | Decode stage tag |
| ex_valid | output | 1 | Execute stage holds an instruction |
| ex_tag | output | 8 | Execute stage tag |
| wb_valid | output | 1 | Write-back stage holds an instruction |
| wb_tag | output | 8 | Write-back stage tag |
| retire | output | 1 | An instruction left write-back on the last edge |
| retire_tag | output | 8 | Tag of the retired instruction |

## Verification
The assertions take for granted that br_taken is raised only while execute holds a valid instruction, and only for one cycle for each branch. They also take for granted that an instruction offered while in_ready is low is offered again, unchanged, until it is accepted. The stimulus meets these conditions because it takes both signals from a behavioural model. That model raises br_taken only when its own execute slot holds an instruction marked as a branch. It advances its program pointer only on cycles where it predicts in_ready is high. After a flush it moves that pointer to the branch target.

// File: rtl/pipe4_pkg.sv
package pipe4_pkg;
    localparam int TAG_W = 8;
    localparam int REG_W = 4;
    localparam int NSRC  = 2;
    localparam int SRC_W = NSRC * REG_W;

    typedef enum logic [1:0] {
        ACT_ADV   = 2'd0,
        ACT_STALL = 2'd1,
        ACT_FLUSH = 2'd2
    } act_e;

    typedef struct packed {
        logic                           valid;
        logic [TAG_W-1:0]               tag;
        logic [NSRC-1:0][REG_W-1:0]     src;
        logic [REG_W-1:0]               dst;
        logic                           wr;
    } slot_t;

    typedef struct packed {
        slot_t              f;
        slot_t              d;
        slot_t              e;
        slot_t              w;
        logic               ret;
        logic [TAG_W-1:0]   ret_tag;
    } pipe_t;

    localparam slot_t SLOT_EMPTY = '0;
endpackage

// File: rtl/pipe4_hazard.sv
module pipe4_hazard
    import pipe4_pkg::*;
(
    input  slot_t dec_slot,
    input  slot_t exe_slot,
    output logic  hazard
);
    logic [NSRC-1:0] src_hit;

    for (genvar gi = 0; gi < NSRC; gi++) begin : g_cmp
        assign src_hit[gi] = (dec_slot.src[gi] == exe_slot.dst);
    end

    assign hazard = dec_slot.valid & exe_slot.valid & exe_slot.wr & (|src_hit);
endmodule

// File: rtl/pipe4_sched.sv
module pipe4_sched
    import pipe4_pkg::*;
(
    input  logic hazard,
    input  logic br_taken,
    output act_e act,
    output logic accept
);
    always_comb begin
        if (br_taken) begin
            act = ACT_FLUSH;
        end else if (hazard) begin
            act = ACT_STALL;
        end else begin
            act = ACT_ADV;
        end
        accept = (act == ACT_ADV);
    end
endmodule

// File: rtl/pipe4_ctrl.sv
module pipe4_ctrl
    import pipe4_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [TAG_W-1:0] in_tag,
    input  logic [SRC_W-1:0] in_src,
    input  logic [REG_W-1:0] in_dst,
    input  logic             in_wr,
    input  logic             br_taken,
    output logic             in_ready,
    output logic             fetch_valid,
    output logic [TAG_W-1:0] fetch_tag,
    output logic             dec_valid,
    output logic [TAG_W-1:0] dec_tag,
    output logic             ex_valid,
    output logic [TAG_W-1:0] ex_tag,
    output logic             wb_valid,
    output logic [TAG_W-1:0] wb_tag,
    output logic             retire,
    output logic [TAG_W-1:0] retire_tag
);
    pipe_t pipe_d, pipe_q;
    logic  hazard;
    act_e  act;
    logic  accept;

    pipe4_hazard u_hazard (
        .dec_slot (pipe_q.d),
        .exe_slot (pipe_q.e),
        .hazard   (hazard)
    );

    pipe4_sched u_sched (
        .hazard   (hazard),
        .br_taken (br_taken),
        .act      (act),
        .accept   (accept)
    );

    always_comb begin
        pipe_d         = pipe_q;
        pipe_d.ret     = pipe_q.w.valid;
        pipe_d.ret_tag = pipe_q.w.tag;
        pipe_d.w       = pipe_q.e;
        case (act)
            ACT_FLUSH: begin
                pipe_d.e = SLOT_EMPTY;
                pipe_d.d = SLOT_EMPTY;
                pipe_d.f = SLOT_EMPTY;
            end
            ACT_STALL: begin
                pipe_d.e = SLOT_EMPTY;
            end
            default: begin
                pipe_d.e = pipe_q.d;
                pipe_d.d = pipe_q.f;
                if (in_valid) begin
                    pipe_d.f.valid = 1'b1;
                    pipe_d.f.tag   = in_tag;
                    pipe_d.f.src   = in_src;
                    pipe_d.f.dst   = in_dst;
                    pipe_d.f.wr    = in_wr;
                end else begin
                    pipe_d.f = SLOT_EMPTY;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign in_ready    = accept;
    assign fetch_valid = pipe_q.f.valid;
    assign fetch_tag   = pipe_q.f.tag;
    assign dec_valid   = pipe_q.d.valid;
    assign dec_tag     = pipe_q.d.tag;
    assign ex_valid    = pipe_q.e.valid;
    assign ex_tag      = pipe_q.e.tag;
    assign wb_valid    = pipe_q.w.valid;
    assign wb_tag      = pipe_q.w.tag;
    assign retire      = pipe_q.ret;
    assign retire_tag  = pipe_q.ret_tag;

    assert_advance_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!br_taken && !hazard && dec_valid) |=> (ex_valid && ex_tag == $past(dec_tag)));

    assert_stall_blocks_input_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hazard |-> !in_ready);

    assert_stall_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (hazard && !br_taken) |=> (dec_valid && $stable(dec_tag) && $stable(fetch_tag)));

    assert_bubble_ex_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (hazard && !br_taken) |=> !ex_valid);

    assert_bubble_wb_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !ex_valid |=> !wb_valid);

    assert_flush_R6: assert property (@(posedge clk) disable iff (!rst_n)
        br_taken |=> (!fetch_valid && !dec_valid && !ex_valid));

    assert_branch_moves_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (br_taken && hazard) |=> (wb_valid && wb_tag == $past(ex_tag)));

    assert_retire_R7: assert property (@(posedge clk) disable iff (!rst_n)
        retire |-> ($past(wb_valid) && retire_tag == $past(wb_tag)));
endmodule

// File: tb/tb_pipe4_ctrl.sv
module tb_pipe4_ctrl;
    localparam int PERIOD = 10;
    localparam int NPROG  = 32;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_tag = '0;
    logic [7:0] in_src = '0;
    logic [3:0] in_dst = '0;
    logic       in_wr = 1'b0;
    logic       br_taken = 1'b0;
    logic       in_ready, fetch_valid, dec_valid, ex_valid, wb_valid, retire;
    logic [7:0] fetch_tag, dec_tag, ex_tag, wb_tag, retire_tag;

    int total = 0;
    int bad   = 0;

    int ptag[NPROG], psa[NPROG], psb[NPROG], pdst[NPROG], ptgt[NPROG];
    bit pwr[NPROG], pbr[NPROG], pgap[NPROG];
    int ms[4];
    int mret;
    int pe_first, lat4;

    always #(PERIOD/2) clk = ~clk;

    pipe4_ctrl dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_tag(in_tag),
        .in_src(in_src), .in_dst(in_dst), .in_wr(in_wr), .br_taken(br_taken),
        .in_ready(in_ready), .fetch_valid(fetch_valid), .fetch_tag(fetch_tag),
        .dec_valid(dec_valid), .dec_tag(dec_tag), .ex_valid(ex_valid), .ex_tag(ex_tag),
        .wb_valid(wb_valid), .wb_tag(wb_tag), .retire(retire), .retire_tag(retire_tag)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic put(input int i, input int sa, input int sb, input int dst, input bit wr,
                       input bit br, input int tgt, input bit gap);
        ptag[i] = 8'h20 + i; psa[i] = sa; psb[i] = sb; pdst[i] = dst;
        pwr[i] = wr; pbr[i] = br; ptgt[i] = tgt; pgap[i] = gap;
    endtask

    task automatic cmp_slot(input int idx, input logic v, input logic [7:0] t, input string nm);
        chk(v == (idx >= 0), "R1 R4", {nm, " valid"}, int'(v), int'(idx >= 0));
        if (idx >= 0) chk(t == ptag[idx][7:0], "R1", {nm, " tag"}, int'(t), ptag[idx]);
    endtask

    task automatic run_prog(input int n, input int limit);
        int  pc, pe, nr;
        bit  gap_used, hz, br, last_br;
        rst_n = 1'b0; in_valid = 1'b0; br_taken = 1'b0;
        repeat (2) @(negedge clk);
        chk(!fetch_valid && !dec_valid && !ex_valid && !wb_valid, "R9", "valid in reset",
            int'({fetch_valid, dec_valid, ex_valid, wb_valid}), 0);
        chk(!retire, "R9", "retire in reset", int'(retire), 0);
        rst_n = 1'b1;
        for (int k = 0; k < 4; k++) ms[k] = -1;
        mret = -1; pc = 0; pe = 0; gap_used = 0; pe_first = -1; lat4 = -1; last_br = 0;
        for (int cyc = 0; cyc < limit; cyc++) begin
            cmp_slot(ms[0], fetch_valid, fetch_tag, last_br ? "fetch R6" : "fetch");
            cmp_slot(ms[1], dec_valid, dec_tag, last_br ? "decode R6" : "decode");
            cmp_slot(ms[2], ex_valid, ex_tag, last_br ? "execute R6" : "execute");
            cmp_slot(ms[3], wb_valid, wb_tag, "writeback");
            chk(retire == (mret >= 0), "R7", "retire", int'(retire), int'(mret >= 0));
            if (mret >= 0) chk(retire_tag == ptag[mret][7:0], "R7", "retire_tag", int'(retire_tag), ptag[mret]);
            if (ms[3] == 3 && lat4 < 0) lat4 = pe - pe_first + 1;
            if (pc >= n && ms[0] < 0 && ms[1] < 0 && ms[2] < 0 && ms[3] < 0 && mret < 0) break;
            hz = (ms[1] >= 0 && ms[2] >= 0 && pwr[ms[2]] &&
                  (psa[ms[1]] == pdst[ms[2]] || psb[ms[1]] == pdst[ms[2]]));
            br = (ms[2] >= 0 && pbr[ms[2]]);
            br_taken = br;
            if (pc < n && !(pgap[pc] && !gap_used)) begin
                in_valid = 1'b1; in_tag = ptag[pc][7:0];
                in_src = {psb[pc][3:0], psa[pc][3:0]}; in_dst = pdst[pc][3:0]; in_wr = pwr[pc];
            end else begin
                in_valid = 1'b0;
            end
            #1;
            chk(in_ready == !(br || hz), br ? (hz ? "R8" : "R6") : "R2 R3", "in_ready",
                int'(in_ready), int'(!(br || hz)));
            nr = ms[3];
            ms[3] = ms[2];
            if (br) begin
                pc = ptgt[ms[2]]; gap_used = 0;
                ms[2] = -1; ms[1] = -1; ms[0] = -1;
            end else if (hz) begin
                ms[2] = -1;
            end else begin
                ms[2] = ms[1]; ms[1] = ms[0];
                if (in_valid) begin
                    ms[0] = pc;
                    if (pc == 0 && pe_first < 0) pe_first = pe + 1;
                    pc++; gap_used = 0;
                end else begin
                    ms[0] = -1;
                    if (pc < n) gap_used = 1;
                end
            end
            mret = nr;
            last_br = br;
            @(negedge clk);
            pe++;
        end
        in_valid = 1'b0; br_taken = 1'b0;
    endtask

    initial begin
        #(PERIOD * 150000);
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        // R5: one dependent pair among four instructions
        put(0, 7, 7, 1, 1, 0, 0, 0);
        put(1, 1, 6, 2, 1, 0, 0, 0);
        put(2, 8, 9, 3, 1, 0, 0, 0);
        put(3, 10, 11, 4, 1, 0, 0, 0);
        run_prog(4, 100);
        chk(lat4 == 8, "R5", "fourth instruction latency with stall", lat4, 8);

        // R5 baseline and R10: no stall for a non-writing producer or a distance-two producer
        put(0, 7, 7, 1, 0, 0, 0, 0);
        put(1, 1, 1, 2, 1, 0, 0, 0);
        put(2, 8, 9, 3, 1, 0, 0, 0);
        put(3, 9, 2, 4, 1, 0, 0, 0);
        run_prog(4, 100);
        chk(lat4 == 7, "R5 R10", "fourth instruction latency without stall", lat4, 7);

        // mixed stream: dependent chain, gaps, branch, branch colliding with a hazard (R8)
        put(0, 0, 0, 1, 1, 0, 0, 0);
        put(1, 1, 0, 2, 1, 0, 0, 0);
        put(2, 2, 1, 3, 1, 0, 0, 1);
        put(3, 5, 6, 7, 1, 0, 0, 0);
        put(4, 8, 8, 9, 1, 1, 8, 0);
        put(5, 1, 1, 1, 1, 0, 0, 0);
        put(6, 1, 1, 1, 1, 0, 0, 0);
        put(7, 1, 1, 1, 1, 0, 0, 0);
        put(8, 3, 4, 5, 1, 1, 11, 0);
        put(9, 5, 0, 6, 1, 0, 0, 0);
        put(10, 6, 6, 6, 1, 0, 0, 0);
        put(11, 5, 12, 10, 1, 0, 0, 1);
        put(12, 10, 0, 11, 1, 0, 0, 0);
        put(13, 11, 10, 12, 0, 0, 0, 0);
        put(14, 12, 12, 13, 1, 0, 0, 0);
        put(15, 0, 0, 14, 1, 0, 0, 1);
        run_prog(16, 400);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule